// File: doc/BRIEF.md
# BCD Seven-Segment Chain Decoder

This block converts one or more 4-bit BCD digits into segment drives for common-anode seven-segment displays. Each segment output is active-low, so a 0 lights the segment. Every digit has three overrides: a lamp test that lights all seven segments, a blank control that turns the whole display dark, and a ripple-blank mechanism that hides a zero digit.

Digits are chained from the most significant position downward. Each digit's ripple-blank output feeds the ripple-blank input of the next lower digit. Leading zeros are therefore suppressed until the first nonzero digit appears. The least significant digit never ripple-blanks, so a value of zero still shows a single 0. The whole datapath is combinational. One shared lamp-test input and one shared blank input drive every digit. A single enable input starts the zero-suppression chain at the top digit.

Top module: `seg_chain_decoder`

## Requirements
- R1: Digit k is read from `digits_i[4k+3:4k]`, with bit 4k+3 as the most significant bit. Its segments leave on `seg_n_o[7k+6:7k]`, ordered a at bit 7k+0 through g at bit 7k+6. Every segment is active-low (0 = lit).
- R2: With all overrides inactive and zero suppression disabled, codes 0 to 9 light the usual glyphs. The glyph for 6 includes segment a and the glyph for 9 includes segment d. Active-high lit patterns (bit 6 = g, bit 0 = a) are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R3: While `blank_n_i` is low, every segment of every digit is 1 (dark), whatever the digits, the lamp test or the ripple state.
- R4: While `blank_n_i` is high and `lamp_test_n_i` is low, every segment of every digit is 0 (lit).
- R5: `ripple_n_o[k]` is 0 exactly when digit k's ripple-blank input is low and digit k is 0000; otherwise it is 1. The lamp test and blank inputs do not affect it.
- R6: Codes 10 to 15 give an all-ones (dark) digit when neither blank nor lamp test is active.
- R7: `zero_suppress_n_i` low drives the top digit's ripple-blank input low. Every lower digit except the last takes its ripple-blank input from the next-higher digit's `ripple_n_o`. Leading zero digits are therefore dark, while the first nonzero digit and all digits after it are shown.
- R8: The least significant digit's ripple-blank input is held high. That digit always shows its value, so an all-zero input shows a single 0 (active-low pattern 1000000), and `ripple_n_o[0]` stays 1.
- R9: With `zero_suppress_n_i` high, zero digits are shown as 0 in every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_i | input | 4*DIGITS | BCD digits, digit 0 least significant |
| lamp_test_n_i | input | 1 | Active-low lamp test, lights all segments |
| blank_n_i | input | 1 | Active-low blank, darkens all digits |
| zero_suppress_n_i | input | 1 | Active-low leading-zero suppression enable (top digit ripple-blank input) |
| seg_n_o | output | 7*DIGITS | Active-low segments a..g per digit |
| ripple_n_o | output | DIGITS | Active-low ripple-blank output of each digit |

## Verification
The hardest situation to reach is a long run of leading zeros spreading through every position of the chain. It should stop at the first nonzero digit and never reach the last digit. It must also do this while lamp test or blank override what the ripple state would display. The stimulus covers this by sweeping every four-digit combination with suppression enabled. It then repeats strided sweeps with suppression disabled, with lamp test held low and with blank held low. In every case the ripple outputs are compared against a digit-by-digit model.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  localparam seg_t SEG_DARK_N = '1;
  localparam seg_t SEG_FULL_N = '0;

  // Active-high lit pattern, bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t glyph_lit(code_t v);
    seg_t s;
    unique case (v)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg_glyph_decode.sv
module seg_glyph_decode
  import seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  lit_o,
  output logic  valid_o,
  output logic  is_zero_o
);
  always_comb begin
    valid_o   = (code_i <= code_t'(MAX_DIGIT));
    is_zero_o = (code_i == '0);
    lit_o     = valid_o ? glyph_lit(code_i) : '0;
  end
endmodule

// File: rtl/seg_digit_stage.sv
module seg_digit_stage
  import seg_pkg::*;
(
  input  code_t code_i,
  input  logic  lamp_test_n_i,
  input  logic  blank_n_i,
  input  logic  rbi_n_i,
  output seg_t  seg_n_o,
  output logic  rbo_n_o
);
  seg_t lit;
  logic valid;
  logic is_zero;
  logic ripple_hit;

  seg_glyph_decode u_glyph (
    .code_i   (code_i),
    .lit_o    (lit),
    .valid_o  (valid),
    .is_zero_o(is_zero)
  );

  assign ripple_hit = !rbi_n_i && is_zero;
  assign rbo_n_o    = !ripple_hit;

  // Priority: blank, lamp test, ripple blank, normal decode.
  always_comb begin
    if (!blank_n_i)          seg_n_o = SEG_DARK_N;
    else if (!lamp_test_n_i) seg_n_o = SEG_FULL_N;
    else if (ripple_hit)     seg_n_o = SEG_DARK_N;
    else if (!valid)         seg_n_o = SEG_DARK_N;
    else                     seg_n_o = ~lit;
  end
endmodule

// File: rtl/seg_chain_decoder.sv
module seg_chain_decoder
  import seg_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [CODE_W*DIGITS-1:0] digits_i,
  input  logic                     lamp_test_n_i,
  input  logic                     blank_n_i,
  input  logic                     zero_suppress_n_i,
  output logic [SEG_W*DIGITS-1:0]  seg_n_o,
  output logic [DIGITS-1:0]        ripple_n_o
);
  logic [DIGITS-1:0] rbi_n;

  generate
    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
      if (k == 0) begin : g_lsd
        assign rbi_n[k] = 1'b1;
      end else if (k == DIGITS-1) begin : g_msd
        assign rbi_n[k] = zero_suppress_n_i;
      end else begin : g_mid
        assign rbi_n[k] = ripple_n_o[k+1];
      end

      seg_digit_stage u_stage (
        .code_i       (digits_i[CODE_W*k +: CODE_W]),
        .lamp_test_n_i(lamp_test_n_i),
        .blank_n_i    (blank_n_i),
        .rbi_n_i      (rbi_n[k]),
        .seg_n_o      (seg_n_o[SEG_W*k +: SEG_W]),
        .rbo_n_o      (ripple_n_o[k])
      );
    end
  endgenerate
endmodule

// File: rtl/seg_chain_chk.sv
module seg_chain_chk
  import seg_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic [CODE_W*DIGITS-1:0] digits_i,
  input logic                     lamp_test_n_i,
  input logic                     blank_n_i,
  input logic                     zero_suppress_n_i,
  input logic [SEG_W*DIGITS-1:0]  seg_n_o,
  input logic [DIGITS-1:0]        ripple_n_o
);
  logic known;
  assign known = !$isunknown({digits_i, lamp_test_n_i, blank_n_i, zero_suppress_n_i});

  always_comb begin
    if (known) begin
      // R3
      blank_dark_chk: assert (blank_n_i || (&seg_n_o))
        else $error("blank did not darken display");
      // R4
      lamp_full_chk: assert (!blank_n_i || lamp_test_n_i || (seg_n_o == '0))
        else $error("lamp test did not light all segments");
      // R8
      lsd_ripple_chk: assert (ripple_n_o[0])
        else $error("least significant digit ripple output asserted");
      for (int k = 0; k < DIGITS; k++) begin
        // R5
        ripple_zero_chk: assert (ripple_n_o[k] || (digits_i[CODE_W*k +: CODE_W] == '0))
          else $error("ripple output low on nonzero digit");
        // R6
        invalid_dark_chk: assert (!blank_n_i || !lamp_test_n_i ||
                                  (digits_i[CODE_W*k +: CODE_W] <= code_t'(MAX_DIGIT)) ||
                                  (&seg_n_o[SEG_W*k +: SEG_W]))
          else $error("invalid code not dark");
      end
    end
  end
endmodule

bind seg_chain_decoder seg_chain_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/tb_seg_chain_decoder.sv
module tb_seg_chain_decoder;
  localparam int ND = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic clk;
  logic [4*ND-1:0] digits;
  logic lt_n, bi_n, zs_n;
  logic [7*ND-1:0] seg_n;
  logic [ND-1:0] rip_n;
  int compared, mismatched;
  bit done;

  seg_chain_decoder #(.DIGITS(ND)) dut (
    .digits_i(digits), .lamp_test_n_i(lt_n), .blank_n_i(bi_n),
    .zero_suppress_n_i(zs_n), .seg_n_o(seg_n), .ripple_n_o(rip_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B; 4'd3: return 7'h4F;
      4'd4: return 7'h66; 4'd5: return 7'h6D; 4'd6: return 7'h7D; 4'd7: return 7'h07;
      4'd8: return 7'h7F; 4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic model(input logic [4*ND-1:0] d, input logic l, input logic b, input logic z,
                       output logic [7*ND-1:0] es, output logic [ND-1:0] er);
    logic rin;
    rin = z;
    for (int k = ND-1; k >= 0; k--) begin
      logic [3:0] v;
      logic in_n;
      v = d[4*k +: 4];
      in_n = (k == 0) ? 1'b1 : rin;
      er[k] = !(!in_n && v == 4'd0);
      if (!b)                     es[7*k +: 7] = 7'h7F;
      else if (!l)                es[7*k +: 7] = 7'h00;
      else if (!in_n && v == 4'd0) es[7*k +: 7] = 7'h7F;
      else                        es[7*k +: 7] = ~glyph(v);
      rin = er[k];
    end
  endtask

  task automatic apply(input logic [4*ND-1:0] d, input logic l, input logic b, input logic z,
                       input string tag);
    logic [7*ND-1:0] es;
    logic [ND-1:0] er;
    @(posedge clk);
    digits = d; lt_n = l; bi_n = b; zs_n = z;
    model(d, l, b, z, es, er);
    @(negedge clk);
    compared++;
    if (seg_n !== es || rip_n !== er) begin
      mismatched++;
      $display("FAIL %s digits=%h seg=%h/%h exp=%h/%h", tag, d, seg_n, rip_n, es, er);
    end
  endtask

  task automatic check_val(input logic [6:0] act, input logic [6:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    compared = 0; mismatched = 0; done = 0;
    digits = '0; lt_n = 1; bi_n = 1; zs_n = 0;
    // R8: all-zero value shows a single 0 in the least significant position
    apply(16'h0000, 1, 1, 0, "R8 all zero");
    check_val(seg_n[6:0], 7'b1000000, "R8 lsd zero glyph");
    check_val(seg_n[27:21], 7'h7F, "R7 msd blanked");
    // R1: field positions and active-low polarity
    apply(16'h0001, 1, 1, 1, "R1 placement");
    check_val(seg_n[6:0], 7'b1111001, "R1 digit0 shows 1");
    check_val(seg_n[13:7], 7'b1000000, "R1 R9 digit1 shows 0");
    // R2: glyphs 6 and 9 include segments a and d
    apply(16'h6009, 1, 1, 1, "R2 six nine");
    check_val(seg_n[27:21], 7'b0000010, "R2 glyph 6");
    check_val(seg_n[6:0], 7'b0010000, "R2 glyph 9");
    // R7: zero between nonzero digits is shown
    apply(16'h0105, 1, 1, 0, "R7 inner zero");
    check_val(seg_n[13:7], 7'b1000000, "R7 inner zero shown");
    // R2 R5 R6 R7 R8: exhaustive sweep with suppression enabled
    for (int v = 0; v < 65536; v++) apply(16'(v), 1, 1, 0, "R2/R5/R6/R7/R8 sweep");
    // R9: suppression disabled
    for (int v = 0; v < 65536; v += 17) apply(16'(v), 1, 1, 1, "R9/R5 sweep");
    // R4: lamp test with suppression active
    for (int v = 0; v < 4096; v++) apply(16'((v * 13) & 16'hFFFF), 0, 1, 0, "R4/R5 lamp test");
    apply(16'h0000, 0, 1, 0, "R4 lamp zero");
    // R3: blank overrides everything
    for (int v = 0; v < 1024; v++) apply(16'(v * 61), 1, 0, 0, "R3 blank");
    for (int v = 0; v < 256; v++) apply(16'(v * 251), 0, 0, 1, "R3 blank over lamp");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule